// File: doc/BRIEF.md
# Windowed Framebuffer Write Address Generator

This block sits between a display command decoder and a packed-pixel framebuffer RAM. Each data byte it receives carries two 4-bit pixels. The block writes the byte to the RAM at the current column and row, then moves the position to the next byte. The framebuffer is 64 bytes wide and 80 rows deep, which makes 5120 bytes, or 128×80 pixels.

A rectangular window limits where writes go. The decoder loads a start and an end for the column range and for the row range. Loading a start also moves the current position to that start.

Two walk orders can be selected at run time:
- Horizontal order fills a row of the window and then moves to the next row.
- Vertical order fills a column of the window and then moves to the next column.

Every accepted byte raises a redraw-pending flag. The scan-out logic clears this flag when it repaints the screen.

Top module: `win_fb_writer`

## Requirements
- R1: After reset `wr_en` and `redraw_pending` are 0. The position is column 0, row 0. The window covers columns 0..63 and rows 0..79.
- R2: A byte is accepted in a cycle when `din_valid` is 1 and neither `col_load` nor `row_load` is 1. One cycle later `wr_en` is 1, `wr_data` equals the byte, and `wr_addr` equals row×64 + column of the position before the advance. Bytes in back-to-back cycles produce back-to-back writes. With no accepted byte, `wr_en` is 0.
- R3: In horizontal order (`vert_mode`=0), the column advances by one after each accepted byte.
  - When the incremented column exceeds the column end, the column returns to the column start and the row advances by one.
  - When that incremented row exceeds the row end, the row returns to the row start.
  - This also holds when the start is above the end.
- R4: In vertical order (`vert_mode`=1), the row advances by one after each accepted byte.
  - When the incremented row exceeds the row end, the row returns to the row start and the column advances by one.
  - When that incremented column exceeds the column end, the column returns to the column start.
- R5: `vert_mode` is sampled with each accepted byte. It may change between any two writes without moving the position.
- R6: `col_load` sets the column start, the column end and the current column. `row_load` does the same for rows.
  - A row value from 80 to 127 is reduced by 80.
  - A load of one axis leaves the other axis unchanged.
- R7: A byte presented in the same cycle as `col_load` or `row_load` is discarded. No write follows it and the position takes the loaded value.
- R8: An accepted byte sets `redraw_pending` one cycle later. `redraw_clr` clears the flag in a cycle with no accepted byte. When both happen in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Display data byte, two pixels |
| din_valid | input | 1 | Data byte strobe |
| col_start_in | input | 6 | Column window start for a load |
| col_end_in | input | 6 | Column window end for a load |
| col_load | input | 1 | Load column window and position |
| row_start_in | input | 7 | Row window start for a load |
| row_end_in | input | 7 | Row window end for a load |
| row_load | input | 1 | Load row window and position |
| vert_mode | input | 1 | 1 = vertical order, 0 = horizontal order |
| redraw_clr | input | 1 | Clear redraw-pending flag |
| wr_en | output | 1 | RAM write enable |
| wr_addr | output | 13 | RAM byte address |
| wr_data | output | 8 | RAM write data |
| redraw_pending | output | 1 | Framebuffer changed since last clear |

## Verification
A long horizontal run from reset walks past the 64th byte. This shows whether the default column end wraps into the next row.

A small loaded window is then filled in both orders. Vertical filling separates the row-first carry from the column-first carry. A window whose start lies above its end exposes wrong wrap comparisons.

Row loads of 80 and above check the reduction. Data arriving with a load shows whether the load has priority.

Random traffic mixes bytes, loads, order flips and clears. This catches interactions between the rules that the directed cases do not reach.

// File: rtl/win_fb_writer.sv
module win_fb_writer #(
  parameter int COL_BYTES = 64,
  parameter int ROWS      = 80,
  parameter int DW        = 8,
  localparam int CW = $clog2(COL_BYTES),
  localparam int RW = $clog2(ROWS),
  localparam int AW = $clog2(COL_BYTES * ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          din_valid,
  input  logic [CW-1:0] col_start_in,
  input  logic [CW-1:0] col_end_in,
  input  logic          col_load,
  input  logic [RW-1:0] row_start_in,
  input  logic [RW-1:0] row_end_in,
  input  logic          row_load,
  input  logic          vert_mode,
  input  logic          redraw_clr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          redraw_pending
);

  logic [CW-1:0] col, col_lo, col_hi;
  logic [RW-1:0] row, row_lo, row_hi;
  logic [CW-1:0] col_n;
  logic [RW-1:0] row_n;

  wire [RW-1:0] row_lo_in = (row_start_in >= RW'(ROWS)) ? row_start_in - RW'(ROWS) : row_start_in;
  wire [RW-1:0] row_hi_in = (row_end_in   >= RW'(ROWS)) ? row_end_in   - RW'(ROWS) : row_end_in;

  wire accept = din_valid & ~col_load & ~row_load;

  wire [CW:0] col_inc  = {1'b0, col} + 1'b1;
  wire [RW:0] row_inc  = {1'b0, row} + 1'b1;
  wire        col_wrap = col_inc > {1'b0, col_hi};
  wire        row_wrap = row_inc > {1'b0, row_hi};
  wire [CW-1:0] col_step = col_wrap ? col_lo : col_inc[CW-1:0];
  wire [RW-1:0] row_step = row_wrap ? row_lo : row_inc[RW-1:0];

  wire [AW-1:0] cur_addr = AW'(row) * AW'(COL_BYTES) + AW'(col);

  always_comb begin
    if (vert_mode) begin
      row_n = row_step;
      col_n = row_wrap ? col_step : col;
    end else begin
      col_n = col_step;
      row_n = col_wrap ? row_step : row;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col    <= '0;
      col_lo <= '0;
      col_hi <= CW'(COL_BYTES - 1);
      row    <= '0;
      row_lo <= '0;
      row_hi <= RW'(ROWS - 1);
    end else begin
      if (accept) begin
        col <= col_n;
        row <= row_n;
      end
      if (col_load) begin
        col    <= col_start_in;
        col_lo <= col_start_in;
        col_hi <= col_end_in;
      end
      if (row_load) begin
        row    <= row_lo_in;
        row_lo <= row_lo_in;
        row_hi <= row_hi_in;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en          <= 1'b0;
      wr_addr        <= '0;
      wr_data        <= '0;
      redraw_pending <= 1'b0;
    end else begin
      wr_en <= accept;
      if (accept) begin
        wr_addr <= cur_addr;
        wr_data <= din;
      end
      if (accept)          redraw_pending <= 1'b1;
      else if (redraw_clr) redraw_pending <= 1'b0;
    end
  end

endmodule

// File: rtl/win_fb_writer_chk.sv
module win_fb_writer_chk #(
  parameter int COL_BYTES = 64,
  parameter int ROWS      = 80,
  parameter int DW        = 8,
  localparam int AW = $clog2(COL_BYTES * ROWS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] din,
  input logic          din_valid,
  input logic          col_load,
  input logic          row_load,
  input logic          redraw_clr,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          redraw_pending
);

  // R2
  addr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_addr) < COL_BYTES * ROWS));

  // R2
  byte_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din_valid && !col_load && !row_load) |=> (wr_en && wr_data == $past(din)));

  // R2
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !din_valid |=> !wr_en);

  // R7
  load_drops_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_load || row_load) |=> !wr_en);

  // R8
  write_flags_redraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> redraw_pending);

  // R8
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (redraw_clr && !din_valid) |=> !redraw_pending);

endmodule

bind win_fb_writer win_fb_writer_chk #(.COL_BYTES(COL_BYTES), .ROWS(ROWS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid),
  .col_load(col_load), .row_load(row_load), .redraw_clr(redraw_clr),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .redraw_pending(redraw_pending)
);

// File: tb/tb_win_fb_writer.sv
`timescale 1ns/1ps
module tb_win_fb_writer;
  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] din;
  logic din_valid, col_load, row_load, vert_mode, redraw_clr;
  logic [5:0] col_start_in, col_end_in;
  logic [6:0] row_start_in, row_end_in;
  logic wr_en, redraw_pending;
  logic [12:0] wr_addr;
  logic [7:0] wr_data;

  int total = 0, bad = 0;
  int m_col, m_row, m_clo, m_chi, m_rlo, m_rhi;
  bit m_red;
  bit done = 0;

  always #2.5 clk = ~clk;

  win_fb_writer dut (
    .clk(clk), .rst_n(rst_n), .din(din), .din_valid(din_valid),
    .col_start_in(col_start_in), .col_end_in(col_end_in), .col_load(col_load),
    .row_start_in(row_start_in), .row_end_in(row_end_in), .row_load(row_load),
    .vert_mode(vert_mode), .redraw_clr(redraw_clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .redraw_pending(redraw_pending)
  );

  function automatic int red80(input int v);
    return (v >= 80) ? v - 80 : v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit dv, input logic [7:0] d, input bit cl,
                     input logic [5:0] cs, input logic [5:0] ce, input bit rl,
                     input logic [6:0] rs, input logic [6:0] re,
                     input bit vm, input bit clr, input string tag);
    bit e_en;
    int e_addr;
    din = d; din_valid = dv; col_load = cl; col_start_in = cs; col_end_in = ce;
    row_load = rl; row_start_in = rs; row_end_in = re; vert_mode = vm; redraw_clr = clr;
    e_en = dv && !cl && !rl;
    e_addr = m_row * 64 + m_col;
    if (e_en) begin
      if (vm) begin
        if (m_row + 1 > m_rhi) begin
          m_row = m_rlo;
          if (m_col + 1 > m_chi) m_col = m_clo; else m_col++;
        end else m_row++;
      end else begin
        if (m_col + 1 > m_chi) begin
          m_col = m_clo;
          if (m_row + 1 > m_rhi) m_row = m_rlo; else m_row++;
        end else m_col++;
      end
    end
    if (cl) begin m_col = cs; m_clo = cs; m_chi = ce; end
    if (rl) begin m_row = red80(rs); m_rlo = red80(rs); m_rhi = red80(re); end
    if (e_en) m_red = 1; else if (clr) m_red = 0;
    @(posedge clk);
    @(negedge clk);
    check({tag, " wr_en"}, wr_en, e_en);
    if (e_en) begin
      check({tag, " wr_addr"}, wr_addr, e_addr);
      check({tag, " wr_data"}, wr_data, d);
    end
    check("R8 redraw", redraw_pending, m_red);
  endtask

  task automatic wr(input bit vm, input string tag);
    cyc(1, 8'($urandom), 0, 0, 0, 0, 0, 0, vm, 0, tag);
  endtask

  task automatic ld(input bit cl, input int cs, input int ce, input bit rl,
                    input int rs, input int re, input bit dv, input string tag);
    cyc(dv, 8'hA5, cl, 6'(cs), 6'(ce), rl, 7'(rs), 7'(re), 0, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; din = 0; din_valid = 0; col_load = 0; row_load = 0;
    vert_mode = 0; redraw_clr = 0; col_start_in = 0; col_end_in = 0;
    row_start_in = 0; row_end_in = 0;
    m_col = 0; m_row = 0; m_clo = 0; m_chi = 63; m_rlo = 0; m_rhi = 79; m_red = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 wr_en at reset", wr_en, 0);
    check("R1 redraw at reset", redraw_pending, 0);
    rst_n = 1;
    // R1 default window: walk past column 63 into row 1
    for (int i = 0; i < 70; i++) wr(0, "R1");
    // R2 idle cycle and R8 clear
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R2");
    // R8 clear together with write keeps flag
    cyc(1, 8'h3C, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
    // R6 load with row values above 79
    ld(1, 10, 12, 1, 85, 86, 0, "R6");
    for (int i = 0; i < 8; i++) wr(0, "R3");
    // R4 vertical in the same window
    ld(1, 10, 12, 1, 5, 6, 0, "R6");
    for (int i = 0; i < 8; i++) wr(1, "R4");
    // R5 switch order mid-stream
    for (int i = 0; i < 6; i++) wr(i[0], "R5");
    // R7 byte with load is discarded
    ld(1, 20, 21, 0, 0, 0, 1, "R7");
    wr(0, "R7");
    ld(0, 0, 0, 1, 70, 71, 1, "R7");
    wr(0, "R7");
    // R3 start above end wraps at once
    ld(1, 5, 3, 1, 9, 2, 0, "R6");
    for (int i = 0; i < 4; i++) wr(0, "R3");
    for (int i = 0; i < 4; i++) wr(1, "R4");
    // R3 bottom-right corner of full memory
    ld(1, 62, 63, 1, 79, 79, 0, "R6");
    for (int i = 0; i < 4; i++) wr(0, "R3");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit dv, cl, rl, vm, clr;
      dv = ($urandom % 10) < 7;
      cl = ($urandom % 20) == 0;
      rl = ($urandom % 20) == 0;
      vm = ($urandom % 8) < 3;
      clr = ($urandom % 10) == 0;
      cyc(dv, 8'($urandom), cl, 6'($urandom), 6'($urandom), rl,
          7'($urandom), 7'($urandom), vm, clr,
          (cl || rl) ? "R7" : (vm ? "R4" : "R3"));
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule